// File: doc/BRIEF.md
# Two-Antenna Space-Time Pair Encoder

This block turns a single stream of complex baseband symbols into two streams, one for each transmit antenna, using a two-slot space-time code. Symbols arrive one per strobe with signed in-phase and quadrature parts. The block collects them in pairs. For every pair (a, b) it emits two consecutive output slots. In the direct slot, antenna 0 carries a and antenna 1 carries b. In the coded slot, antenna 0 carries the negated conjugate of b and antenna 1 carries the conjugate of a.

Conjugation flips the sign of the quadrature part. Negating a symbol flips the sign of both parts. Every sign flip saturates: the most negative code becomes the most positive code instead of wrapping back to itself.

Upstream logic pads each block to an even symbol count and marks the last symbol of a block. If a marked symbol would open a new pair, it has no partner. That symbol is dropped and an error pulse is raised. The output timing is fixed, so the antenna streams can feed the transform stages directly.

Top module: `stbc_pair_encoder`

## Requirements
- R1: In the direct slot of a pair (a, b), `ant0_i/ant0_q` equal a and `ant1_i/ant1_q` equal b.
- R2: In the coded slot, antenna 0 carries (−b.i, b.q) and antenna 1 carries (a.i, −a.q).
- R3: Negating the most negative value (−256 at the default 9-bit width) gives +255, both for the antenna 0 in-phase part and for the antenna 1 quadrature part of the coded slot.
- R4: The direct slot is visible after the second rising edge following the edge that accepts b. The coded slot follows in the next cycle. `tx_valid` is high in exactly those two cycles per pair. For back-to-back input, this places the first output 3 edges after the edge that accepts a.
- R5: Cycles with `sym_valid` low are ignored. Gaps of any length between a and b, or between pairs, change only when the pair completes.
- R6: A symbol accepted with `sym_last` high while no symbol is held is discarded. `odd_err` is high for exactly the one cycle after that edge, and no output slot results. The next accepted symbol opens a new pair.
- R7: `sym_last` on the second symbol of a pair causes no error, and the pair is encoded normally.
- R8: A synchronous active-high `rst` clears the held symbol and all outputs. A symbol held before reset is never paired with a symbol that arrives after reset.
- R9: While `tx_valid` is low, all four antenna outputs read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Input symbol strobe |
| sym_i | input | 9 | In-phase part, two's complement |
| sym_q | input | 9 | Quadrature part, two's complement |
| sym_last | input | 1 | Marks the last symbol of a block |
| tx_valid | output | 1 | Antenna outputs carry a slot |
| ant0_i | output | 9 | Antenna 0 in-phase part |
| ant0_q | output | 9 | Antenna 0 quadrature part |
| ant1_i | output | 9 | Antenna 1 in-phase part |
| ant1_q | output | 9 | Antenna 1 quadrature part |
| odd_err | output | 1 | One-cycle pulse for an unpaired trailing symbol |

## Verification
A sweep drives back-to-back pairs in which each symbol part steps through all 512 codes. The sweep brings the second symbol's in-phase part and the first symbol's quadrature part to −256, which separates saturating negation from wrapping negation and catches swapped antennas or swapped slots.

Irregular gaps between symbols show whether the pairing follows accepted symbols or raw cycles. A marked lone symbol followed by a marked even block shows whether the error path and the normal end of a block are kept apart. A reset between the two symbols of a pair shows whether a stale held symbol leaks into the next pair.

// File: rtl/stbc_pkg.sv
package stbc_pkg;
    typedef enum logic {
        SLOT_DIRECT = 1'b0,
        SLOT_CODED  = 1'b1
    } stbc_slot_e;
endpackage

// File: rtl/stbc_pair_collect.sv
module stbc_pair_collect #(
    parameter int W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid_i,
    input  logic signed [W-1:0] in_i_i,
    input  logic signed [W-1:0] in_q_i,
    input  logic                in_last_i,
    output logic                pr_valid_o,
    output logic signed [W-1:0] pr_ai_o,
    output logic signed [W-1:0] pr_aq_o,
    output logic signed [W-1:0] pr_bi_o,
    output logic signed [W-1:0] pr_bq_o,
    output logic                odd_err_o
);
    typedef struct packed {
        logic                held;
        logic signed [W-1:0] hi;
        logic signed [W-1:0] hq;
        logic                pv;
        logic signed [W-1:0] ai;
        logic signed [W-1:0] aq;
        logic signed [W-1:0] bi;
        logic signed [W-1:0] bq;
        logic                err;
    } col_t;

    col_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pv  = 1'b0;
        st_d.err = 1'b0;
        if (in_valid_i) begin
            if (!st_q.held) begin
                if (in_last_i) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.held = 1'b1;
                    st_d.hi   = in_i_i;
                    st_d.hq   = in_q_i;
                end
            end else begin
                st_d.held = 1'b0;
                st_d.pv   = 1'b1;
                st_d.ai   = st_q.hi;
                st_d.aq   = st_q.hq;
                st_d.bi   = in_i_i;
                st_d.bq   = in_q_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pr_valid_o = st_q.pv;
    assign pr_ai_o    = st_q.ai;
    assign pr_aq_o    = st_q.aq;
    assign pr_bi_o    = st_q.bi;
    assign pr_bq_o    = st_q.bq;
    assign odd_err_o  = st_q.err;

    // R6
    lone_err_chk: assert property (@(posedge clk) disable iff (rst)
        odd_err_o |-> $past(in_valid_i && in_last_i));

    // R6
    err_no_pair_chk: assert property (@(posedge clk) disable iff (rst)
        odd_err_o |-> !pr_valid_o);
endmodule

// File: rtl/stbc_code_emit.sv
module stbc_code_emit
    import stbc_pkg::*;
#(
    parameter int W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pr_valid_i,
    input  logic signed [W-1:0] pr_ai_i,
    input  logic signed [W-1:0] pr_aq_i,
    input  logic signed [W-1:0] pr_bi_i,
    input  logic signed [W-1:0] pr_bq_i,
    output logic                out_valid_o,
    output logic signed [W-1:0] a0_i_o,
    output logic signed [W-1:0] a0_q_o,
    output logic signed [W-1:0] a1_i_o,
    output logic signed [W-1:0] a1_q_o
);
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

    function automatic logic signed [W-1:0] sat_neg(input logic signed [W-1:0] x);
        if (x == MINV) return MAXV;
        return -x;
    endfunction

    typedef struct packed {
        logic                v2;
        logic signed [W-1:0] ai;
        logic signed [W-1:0] aq;
        logic signed [W-1:0] bi;
        logic signed [W-1:0] bq;
        logic                coded_due;
        logic                ov;
        stbc_slot_e          slot;
        logic signed [W-1:0] o0i;
        logic signed [W-1:0] o0q;
        logic signed [W-1:0] o1i;
        logic signed [W-1:0] o1q;
    } emit_t;

    emit_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.v2        = pr_valid_i;
        if (pr_valid_i) begin
            st_d.ai = pr_ai_i;
            st_d.aq = pr_aq_i;
            st_d.bi = pr_bi_i;
            st_d.bq = pr_bq_i;
        end
        st_d.coded_due = 1'b0;
        st_d.ov        = 1'b0;
        st_d.slot      = SLOT_DIRECT;
        st_d.o0i       = '0;
        st_d.o0q       = '0;
        st_d.o1i       = '0;
        st_d.o1q       = '0;
        if (st_q.v2) begin
            st_d.ov        = 1'b1;
            st_d.coded_due = 1'b1;
            st_d.o0i       = st_q.ai;
            st_d.o0q       = st_q.aq;
            st_d.o1i       = st_q.bi;
            st_d.o1q       = st_q.bq;
        end else if (st_q.coded_due) begin
            st_d.ov   = 1'b1;
            st_d.slot = SLOT_CODED;
            st_d.o0i  = sat_neg(st_q.bi);
            st_d.o0q  = st_q.bq;
            st_d.o1i  = st_q.ai;
            st_d.o1q  = sat_neg(st_q.aq);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid_o = st_q.ov;
    assign a0_i_o      = st_q.o0i;
    assign a0_q_o      = st_q.o0q;
    assign a1_i_o      = st_q.o1i;
    assign a1_q_o      = st_q.o1q;

    // R4
    slot_timing_chk: assert property (@(posedge clk) disable iff (rst)
        pr_valid_i |-> ##2 (out_valid_o && st_q.slot == SLOT_DIRECT)
                       ##1 (out_valid_o && st_q.slot == SLOT_CODED));

    // R4
    slot_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !(st_q.v2 && st_q.coded_due));

    // R2
    coded_keeps_a_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && st_q.slot == SLOT_CODED) |-> (a1_i_o == $past(a0_i_o)));

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid_o);
endmodule

// File: rtl/stbc_pair_encoder.sv
module stbc_pair_encoder #(
    parameter int W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sym_valid,
    input  logic signed [W-1:0] sym_i,
    input  logic signed [W-1:0] sym_q,
    input  logic                sym_last,
    output logic                tx_valid,
    output logic signed [W-1:0] ant0_i,
    output logic signed [W-1:0] ant0_q,
    output logic signed [W-1:0] ant1_i,
    output logic signed [W-1:0] ant1_q,
    output logic                odd_err
);
    logic                pr_valid;
    logic signed [W-1:0] pr_ai, pr_aq, pr_bi, pr_bq;

    stbc_pair_collect #(.W(W)) u_collect (
        .clk        (clk),
        .rst        (rst),
        .in_valid_i (sym_valid),
        .in_i_i     (sym_i),
        .in_q_i     (sym_q),
        .in_last_i  (sym_last),
        .pr_valid_o (pr_valid),
        .pr_ai_o    (pr_ai),
        .pr_aq_o    (pr_aq),
        .pr_bi_o    (pr_bi),
        .pr_bq_o    (pr_bq),
        .odd_err_o  (odd_err)
    );

    stbc_code_emit #(.W(W)) u_emit (
        .clk         (clk),
        .rst         (rst),
        .pr_valid_i  (pr_valid),
        .pr_ai_i     (pr_ai),
        .pr_aq_i     (pr_aq),
        .pr_bi_i     (pr_bi),
        .pr_bq_i     (pr_bq),
        .out_valid_o (tx_valid),
        .a0_i_o      (ant0_i),
        .a0_q_o      (ant0_q),
        .a1_i_o      (ant1_i),
        .a1_q_o      (ant1_q)
    );
endmodule

// File: tb/tb_stbc_pair_encoder.sv
module tb_stbc_pair_encoder;
    localparam int W = 9;
    localparam int N = 16384;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                sym_valid = 1'b0;
    logic signed [W-1:0] sym_i = '0;
    logic signed [W-1:0] sym_q = '0;
    logic                sym_last = 1'b0;
    logic                tx_valid, odd_err;
    logic signed [W-1:0] ant0_i, ant0_q, ant1_i, ant1_q;

    stbc_pair_encoder #(.W(W)) dut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
        .sym_last(sym_last), .tx_valid(tx_valid), .ant0_i(ant0_i), .ant0_q(ant0_q),
        .ant1_i(ant1_i), .ant1_q(ant1_q), .odd_err(odd_err)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int failed = 0;

    bit ev   [N];
    bit eerr [N];
    int etag [N];
    int e0i [N], e0q [N], e1i [N], e1q [N];

    bit held = 0;
    int hi = 0, hq = 0;
    int vtag = 4;

    function automatic string tname(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            5: return "R5";
            8: return "R8";
            default: return "R4";
        endcase
    endfunction

    function automatic int sneg(int x);
        return (x == -256) ? 255 : -x;
    endfunction

    task automatic push(int i, int q, bit last);
        int n;
        @(negedge clk);
        sym_valid = 1'b1;
        sym_i     = W'(i);
        sym_q     = W'(q);
        sym_last  = last;
        n = cyc + 1;
        if (!held) begin
            if (last) eerr[n % N] = 1'b1;
            else begin held = 1; hi = i; hq = q; end
        end else begin
            held = 0;
            ev[(n+2) % N] = 1'b1; etag[(n+2) % N] = 1;
            e0i[(n+2) % N] = hi; e0q[(n+2) % N] = hq;
            e1i[(n+2) % N] = i;  e1q[(n+2) % N] = q;
            ev[(n+3) % N] = 1'b1;
            etag[(n+3) % N] = (i == -256 || hq == -256) ? 3 : 2;
            e0i[(n+3) % N] = sneg(i); e0q[(n+3) % N] = q;
            e1i[(n+3) % N] = hi;      e1q[(n+3) % N] = sneg(hq);
        end
    endtask

    task automatic idle(int k);
        for (int j = 0; j < k; j++) begin
            @(negedge clk);
            sym_valid = 1'b0;
            sym_last  = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        int k;
        k = cyc % N;
        if (rst) begin
            if (cyc > 0) begin
                total++;
                if (tx_valid !== 1'b0 || odd_err !== 1'b0 || ant0_i !== '0 || ant1_q !== '0) begin
                    failed++;
                    $display("FAIL R8 reset outputs v=%b e=%b a0i=%0d a1q=%0d exp all 0",
                             tx_valid, odd_err, ant0_i, ant1_q);
                end
            end
        end else begin
            total++;
            if (tx_valid !== ev[k]) begin
                failed++;
                $display("FAIL %s tx_valid at cycle %0d got %b exp %b", tname(vtag), cyc, tx_valid, ev[k]);
            end else if (ev[k]) begin
                total++;
                if (int'(ant0_i) != e0i[k] || int'(ant0_q) != e0q[k] ||
                    int'(ant1_i) != e1i[k] || int'(ant1_q) != e1q[k]) begin
                    failed++;
                    $display("FAIL %s slot at cycle %0d got (%0d,%0d)(%0d,%0d) exp (%0d,%0d)(%0d,%0d)",
                             tname(etag[k]), cyc, ant0_i, ant0_q, ant1_i, ant1_q,
                             e0i[k], e0q[k], e1i[k], e1q[k]);
                end
            end else begin
                total++;
                if (ant0_i != 0 || ant0_q != 0 || ant1_i != 0 || ant1_q != 0) begin
                    failed++;
                    $display("FAIL R9 idle outputs (%0d,%0d)(%0d,%0d) exp zeros",
                             ant0_i, ant0_q, ant1_i, ant1_q);
                end
            end
            total++;
            if (odd_err !== eerr[k]) begin
                failed++;
                if (eerr[k]) $display("FAIL R6 odd_err at cycle %0d got %b exp 1", cyc, odd_err);
                else         $display("FAIL R7 odd_err at cycle %0d got %b exp 0", cyc, odd_err);
            end
        end
        ev[k] = 1'b0; eerr[k] = 1'b0;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 R2 R3 R4: full-range sweep, back to back
        for (int v = -256; v < 256; v++) begin
            push(v, ((v + 300) % 512) - 256, 1'b0);
            push(-1 - v, v, 1'b0);
        end
        idle(6);

        // R5: gaps inside and between pairs
        vtag = 5;
        for (int g = 0; g < 6; g++) begin
            push(g * 40 - 100, 77 - g, 1'b0);
            idle(g);
            push(-g, g * 30 - 128, 1'b0);
            idle(g % 3);
        end
        idle(6);

        // R6: lone marked symbol; R7: marked second symbol
        vtag = 4;
        push(12, -34, 1'b1);
        idle(2);
        push(5, 6, 1'b0);
        push(-7, 8, 1'b1);
        push(100, 101, 1'b1);
        push(-256, -256, 1'b0);
        push(-256, -256, 1'b1);
        idle(6);

        // R8: reset between the two symbols of a pair
        vtag = 8;
        push(50, 60, 1'b0);
        @(negedge clk);
        sym_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        held = 0;
        push(-3, 4, 1'b0);
        push(9, -10, 1'b0);
        idle(6);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failed++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule